// File: doc/BRIEF.md
# TDMA Burst Event Timer

The block times transmit and receive bursts on a time-division baseband link. Two counters run from reset onwards. A quarter-bit counter counts every clock. A frame counter steps each time the quarter-bit counter wraps. A host loads a 148-bit transmit burst and an event target through a 16-bit register port. The target is a frame number and a quarter-bit position. The host then arms the event by writing a control word.

When both counters equal the target, the block does one of two things:
- It serializes the stored burst, one bit per four quarter-bit ticks.
- It opens a receive window that collects I/Q sample pairs into two alternating halves of a buffer.

Completion of a burst and every filled buffer half each set a sticky status bit. Those bits drive the interrupt line.

The controller is a four-state machine:
- `S_IDLE`: nothing pending.
- `S_ARMED`: an event is waiting for its time.
- `S_TX`: the burst is being shifted out.
- `S_RX`: the receive window is open.

It has five transitions:
- `S_IDLE` to `S_ARMED` on an accepted control write.
- `S_ARMED` to `S_ARMED` on a rewrite. The new event replaces the pending one.
- `S_ARMED` to `S_TX` or `S_RX` on a time match, chosen by the mode bit.
- `S_TX` to `S_IDLE` after the last bit.
- `S_RX` to `S_IDLE` after the last requested buffer half fills.

Top module: `tdma_burst_sched`

## Requirements
- R1: `qb_count` counts 0 to 4999 and then returns to 0. `frame_count` increases by one on each such wrap and wraps from 2715647 to 0. Both counters are 0 after reset.
- R2: Burst words are written at addresses 0x00 to 0x09. Bits go out word 0 first, and within each word bit 0 first. Only 148 bits are sent, so bits 4 to 15 of word 9 never appear.
- R3: The target registers are:
  - 0x10: quarter-bit position.
  - 0x11: frame bits 15:0.
  - 0x12: frame bits 21:16.

  A write to 0x13 arms the event. In that word, bit 0 selects the action (0 transmit, 1 receive). The action begins in the cycle after the counters equal the target, so `qb_count` reads the target plus one in the first active cycle. The event fires once.
- R4: A control write while an event is armed replaces the pending event. Only the new time takes effect.
- R5: During a transmit, `tx_busy` is high. Each bit is held on `tx_bit` for 4 clocks, and `tx_strobe` pulses in the first of those clocks. Exactly 148 strobes occur.
- R6: After the last transmit bit, `tx_busy` falls and status bit 0 (transmit done) is set.
- R7: During a receive, `rx_win` is high and a pair is taken on each cycle with `rx_valid`. Control bits 4:1 give the number of 32-pair halves to collect, with 0 treated as 1. The window closes after the last half fills.
- R8: The first half filled in a window is half 0, and the halves then alternate. Each filled half sets status bit 1 and records that half's number in status bit 4. Pair n of half h is read at address 0x40 + 32·h + n as {I, Q}.
- R9: Status lives at 0x14. Writing 1 to any of bits 0 to 2 clears that bit, and writing 0 leaves it unchanged. Status bit 3 reads 1 while an event is armed.
- R10: `irq` is high when any of status bits 0 to 2 is set and the matching bit of the enable register at 0x15 is also set.
- R11: During a transmit, a burst-word write is ignored. A control write during a transmit or a receive is also ignored. Each of these rejected writes sets status bit 2 (error).
- R12: After reset, the machine is idle, every status bit is 0, and `irq`, `tx_busy`, `tx_strobe` and `rx_win` are low.
- R13: Register reads return data one clock after `host_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one quarter-bit tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 7 | Register address |
| host_wdata | input | 16 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 16 | Read data, registered |
| tx_bit | output | 1 | Serialized burst bit |
| tx_strobe | output | 1 | Pulse at the start of each bit |
| tx_busy | output | 1 | Transmit in progress |
| rx_win | output | 1 | Receive window open |
| rx_valid | input | 1 | I/Q pair present |
| rx_i | input | 8 | In-phase sample |
| rx_q | input | 8 | Quadrature sample |
| irq | output | 1 | Interrupt request |
| qb_count | output | 13 | Quarter-bit counter |
| frame_count | output | 22 | Frame counter |

## Verification
A scoreboard compares the serialized bits against a model built from the written words and checks when the first strobe appears relative to the target. A design that starts one cycle early or late, or that numbers the bits in the wrong order, fails there.

A burst word rewritten mid-transmit must leave both that burst and the next one unchanged. A design that leaks the write into storage shows different tail bits.

Two further cases cover the control word. A rewritten event must fire only at the new time. A receive with a block count of zero must still close after one half. A design that loops on the zero count leaves `rx_win` high. Status clearing must ignore written zeros.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_TX    = 2'd2,
        S_RX    = 2'd3
    } state_t;

    localparam int A_EV_QB  = 'h10;
    localparam int A_EV_FLO = 'h11;
    localparam int A_EV_FHI = 'h12;
    localparam int A_CTRL   = 'h13;
    localparam int A_STAT   = 'h14;
    localparam int A_IEN    = 'h15;

    localparam int ST_DONE = 0;
    localparam int ST_RXRDY = 1;
    localparam int ST_ERR  = 2;
endpackage

// File: rtl/tdma_clock.sv
module tdma_clock #(
    parameter int QB_PER_FRAME = 5000,
    parameter int FRAME_MOD    = 2715648,
    localparam int QB_W = $clog2(QB_PER_FRAME),
    localparam int FR_W = $clog2(FRAME_MOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [QB_W-1:0] qb_o,
    output logic [FR_W-1:0] frame_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qb_o    <= '0;
            frame_o <= '0;
        end else if (qb_o == QB_W'(QB_PER_FRAME - 1)) begin
            qb_o    <= '0;
            frame_o <= (frame_o == FR_W'(FRAME_MOD - 1)) ? '0 : frame_o + 1'b1;
        end else begin
            qb_o <= qb_o + 1'b1;
        end
    end
endmodule

// File: rtl/tdma_burst_store.sv
module tdma_burst_store #(
    parameter int BITS   = 148,
    parameter int WORD_W = 16,
    localparam int NW    = (BITS + WORD_W - 1) / WORD_W,
    localparam int WA_W  = $clog2(NW),
    localparam int IDX_W = $clog2(NW * WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WA_W-1:0]   waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  bidx,
    output logic              bit_o
);
    logic [NW*WORD_W-1:0] flat;

    for (genvar w = 0; w < NW; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flat[w*WORD_W +: WORD_W] <= '0;
            else if (we && waddr == WA_W'(w))
                flat[w*WORD_W +: WORD_W] <= wdata;
        end
    end

    assign bit_o = flat[bidx];
endmodule

// File: rtl/tdma_rx_dbuf.sv
module tdma_rx_dbuf #(
    parameter int PAIRS    = 32,
    parameter int SAMPLE_W = 8,
    localparam int PAIR_W  = $clog2(PAIRS)
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic                  whalf,
    input  logic [PAIR_W-1:0]     widx,
    input  logic [SAMPLE_W-1:0]   wi,
    input  logic [SAMPLE_W-1:0]   wq,
    input  logic [PAIR_W:0]       raddr,
    output logic [2*SAMPLE_W-1:0] rdata
);
    logic [2*SAMPLE_W-1:0] mem [2*PAIRS];

    always_ff @(posedge clk) begin
        if (we) mem[{whalf, widx}] <= {wi, wq};
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tdma_burst_sched.sv
module tdma_burst_sched
    import tdma_pkg::*;
#(
    parameter int QB_PER_FRAME = 5000,
    parameter int FRAME_MOD    = 2715648,
    parameter int BURST_BITS   = 148,
    parameter int WORD_W       = 16,
    parameter int QB_PER_BIT   = 4,
    parameter int PAIRS        = 32,
    parameter int SAMPLE_W     = 8,
    parameter int ADDR_W       = 7,
    localparam int QB_W   = $clog2(QB_PER_FRAME),
    localparam int FR_W   = $clog2(FRAME_MOD)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [WORD_W-1:0]   host_wdata,
    input  logic                host_wr,
    input  logic                host_rd,
    output logic [WORD_W-1:0]   host_rdata,
    output logic                tx_bit,
    output logic                tx_strobe,
    output logic                tx_busy,
    output logic                rx_win,
    input  logic                rx_valid,
    input  logic [SAMPLE_W-1:0] rx_i,
    input  logic [SAMPLE_W-1:0] rx_q,
    output logic                irq,
    output logic [QB_W-1:0]     qb_count,
    output logic [FR_W-1:0]     frame_count
);
    localparam int NWORDS = (BURST_BITS + WORD_W - 1) / WORD_W;
    localparam int WA_W   = $clog2(NWORDS);
    localparam int BIDX_W = $clog2(NWORDS * WORD_W);
    localparam int TICK_W = (QB_PER_BIT > 1) ? $clog2(QB_PER_BIT) : 1;
    localparam int PAIR_W = $clog2(PAIRS);

    state_t st_q, st_d;

    logic [QB_W-1:0]     ev_qb_q;
    logic [FR_W-1:0]     ev_fr_q;
    logic                mode_q;
    logic [3:0]          blocks_q, blk_q, blk_tgt;
    logic [2:0]          sticky_q, ien_q, st_set, st_clr;
    logic                ready_half_q, wr_half_q;
    logic [TICK_W-1:0]   tick_q;
    logic [BIDX_W-1:0]   bit_q;
    logic [PAIR_W-1:0]   pair_q;
    logic [WORD_W-1:0]   rdata_q;
    logic [2*SAMPLE_W-1:0] buf_rdata;
    logic                burst_bit, hit, ctrl_wr, ctrl_ok, burst_wr, fire;
    logic                tx_last, rx_take, half_full, rx_last, err_ev;

    tdma_clock #(.QB_PER_FRAME(QB_PER_FRAME), .FRAME_MOD(FRAME_MOD)) u_clock (
        .clk(clk), .rst_n(rst_n), .qb_o(qb_count), .frame_o(frame_count));

    assign burst_wr = host_wr && (host_addr < ADDR_W'(NWORDS));

    tdma_burst_store #(.BITS(BURST_BITS), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(burst_wr && st_q != S_TX),
        .waddr(host_addr[WA_W-1:0]), .wdata(host_wdata),
        .bidx(bit_q), .bit_o(burst_bit));

    tdma_rx_dbuf #(.PAIRS(PAIRS), .SAMPLE_W(SAMPLE_W)) u_rxbuf (
        .clk(clk), .we(rx_take), .whalf(wr_half_q), .widx(pair_q),
        .wi(rx_i), .wq(rx_q), .raddr(host_addr[PAIR_W:0]), .rdata(buf_rdata));

    // Event decode and sequencing conditions
    assign hit       = (qb_count == ev_qb_q) && (frame_count == ev_fr_q);
    assign ctrl_wr   = host_wr && host_addr == ADDR_W'(A_CTRL);
    assign ctrl_ok   = ctrl_wr && (st_q == S_IDLE || st_q == S_ARMED);
    assign fire      = (st_q == S_ARMED) && !ctrl_ok && hit;
    assign tx_last   = (st_q == S_TX) && tick_q == TICK_W'(QB_PER_BIT - 1)
                       && bit_q == BIDX_W'(BURST_BITS - 1);
    assign rx_take   = (st_q == S_RX) && rx_valid;
    assign half_full = rx_take && pair_q == PAIR_W'(PAIRS - 1);
    assign blk_tgt   = (blocks_q == 4'd0) ? 4'd1 : blocks_q;
    assign rx_last   = half_full && (blk_q + 4'd1 == blk_tgt);
    assign err_ev    = (burst_wr && st_q == S_TX) || (ctrl_wr && !ctrl_ok);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (ctrl_ok) st_d = S_ARMED;
            S_ARMED: if (fire)    st_d = mode_q ? S_RX : S_TX;
            S_TX:    if (tx_last) st_d = S_IDLE;
            S_RX:    if (rx_last) st_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx_busy   = (st_q == S_TX);
        tx_strobe = tx_busy && tick_q == '0;
        tx_bit    = tx_busy && burst_bit;
        rx_win    = (st_q == S_RX);
        irq       = |(sticky_q & ien_q);
        host_rdata = rdata_q;
    end

    assign st_set = {err_ev, half_full, tx_last};
    assign st_clr = (host_wr && host_addr == ADDR_W'(A_STAT)) ? host_wdata[2:0] : 3'b000;

    // Registers and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_qb_q <= '0; ev_fr_q <= '0; mode_q <= 1'b0; blocks_q <= '0;
            ien_q <= '0; sticky_q <= '0; ready_half_q <= 1'b0; wr_half_q <= 1'b0;
            tick_q <= '0; bit_q <= '0; pair_q <= '0; blk_q <= '0; rdata_q <= '0;
        end else begin
            if (host_wr && host_addr == ADDR_W'(A_EV_QB))  ev_qb_q <= host_wdata[QB_W-1:0];
            if (host_wr && host_addr == ADDR_W'(A_EV_FLO)) ev_fr_q[WORD_W-1:0] <= host_wdata;
            if (host_wr && host_addr == ADDR_W'(A_EV_FHI))
                ev_fr_q[FR_W-1:WORD_W] <= host_wdata[FR_W-WORD_W-1:0];
            if (host_wr && host_addr == ADDR_W'(A_IEN)) ien_q <= host_wdata[2:0];
            if (ctrl_ok) begin
                mode_q   <= host_wdata[0];
                blocks_q <= host_wdata[4:1];
            end
            sticky_q <= (sticky_q & ~st_clr) | st_set;

            if (fire) begin
                tick_q <= '0; bit_q <= '0; pair_q <= '0; wr_half_q <= 1'b0; blk_q <= '0;
            end
            if (st_q == S_TX) begin
                if (tick_q == TICK_W'(QB_PER_BIT - 1)) begin
                    tick_q <= '0;
                    bit_q  <= bit_q + 1'b1;
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end
            if (rx_take) begin
                pair_q <= half_full ? '0 : pair_q + 1'b1;
                if (half_full) begin
                    ready_half_q <= wr_half_q;
                    wr_half_q    <= ~wr_half_q;
                    blk_q        <= blk_q + 4'd1;
                end
            end

            if (host_rd) begin
                if (host_addr[ADDR_W-1]) begin
                    rdata_q <= WORD_W'(buf_rdata);
                end else begin
                    case (host_addr)
                        ADDR_W'(A_EV_QB):  rdata_q <= WORD_W'(ev_qb_q);
                        ADDR_W'(A_EV_FLO): rdata_q <= ev_fr_q[WORD_W-1:0];
                        ADDR_W'(A_EV_FHI): rdata_q <= WORD_W'(ev_fr_q[FR_W-1:WORD_W]);
                        ADDR_W'(A_STAT):   rdata_q <= WORD_W'({ready_half_q, st_q == S_ARMED, sticky_q});
                        ADDR_W'(A_IEN):    rdata_q <= WORD_W'(ien_q);
                        default:           rdata_q <= '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/tdma_burst_sched_chk.sv
module tdma_burst_sched_chk #(
    parameter int QB_PER_FRAME = 5000,
    parameter int FRAME_MOD    = 2715648,
    parameter int NWORDS       = 10,
    parameter int ADDR_W       = 7,
    localparam int QB_W = $clog2(QB_PER_FRAME),
    localparam int FR_W = $clog2(FRAME_MOD)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [QB_W-1:0]   qb_count,
    input logic [FR_W-1:0]   frame_count,
    input logic              tx_strobe,
    input logic              tx_busy,
    input logic              rx_win,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [2:0]        sticky_q
);
    localparam logic [QB_W-1:0] QB_MAX = QB_W'(QB_PER_FRAME - 1);
    localparam logic [FR_W-1:0] FR_MAX = FR_W'(FRAME_MOD - 1);

    p_qb_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        qb_count == QB_MAX |=> qb_count == '0);
    p_qb_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        qb_count != QB_MAX |=> qb_count == $past(qb_count) + 1'b1);
    p_frame_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        qb_count != QB_MAX |=> $stable(frame_count));
    p_frame_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (qb_count == QB_MAX && frame_count != FR_MAX) |=> frame_count == $past(frame_count) + 1'b1);
    p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (qb_count == QB_MAX && frame_count == FR_MAX) |=> frame_count == '0);
    p_strobe_in_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> tx_busy);
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> !tx_strobe);
    p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> sticky_q[0]);
    p_half_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_win) |-> sticky_q[1]);
    p_modes_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_busy && rx_win));
    p_reject_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && host_wr && host_addr < ADDR_W'(NWORDS)) |=> sticky_q[2]);
endmodule

bind tdma_burst_sched tdma_burst_sched_chk #(
    .QB_PER_FRAME(QB_PER_FRAME), .FRAME_MOD(FRAME_MOD),
    .NWORDS(NWORDS), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .qb_count(qb_count), .frame_count(frame_count),
    .tx_strobe(tx_strobe), .tx_busy(tx_busy), .rx_win(rx_win),
    .host_wr(host_wr), .host_addr(host_addr), .sticky_q(sticky_q)
);

// File: tb/sim_tdma_burst_sched.sv
module sim_tdma_burst_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_rdata;
    logic        tx_bit, tx_strobe, tx_busy, rx_win, irq;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_i = '0, rx_q = '0;
    logic [12:0] qb_count;
    logic [21:0] frame_count;

    int errors = 0, checks = 0;
    bit exp_q[$];
    int strobes = 0, first_qb = -1, first_fr = -1, last_cyc = 0, gap_bad = 0, cyc = 0;
    logic [15:0] words [10];

    always #4 clk = ~clk;

    tdma_burst_sched u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_bit(tx_bit), .tx_strobe(tx_strobe), .tx_busy(tx_busy), .rx_win(rx_win),
        .rx_valid(rx_valid), .rx_i(rx_i), .rx_q(rx_q), .irq(irq),
        .qb_count(qb_count), .frame_count(frame_count));

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pops expected bits at every strobe
    always @(negedge clk) begin
        cyc++;
        if (rst_n && tx_strobe) begin
            if (strobes == 0) begin
                first_qb = int'(qb_count);
                first_fr = int'(frame_count);
            end else if (cyc - last_cyc != 4) begin
                gap_bad++;
            end
            last_cyc = cyc;
            strobes++;
            if (exp_q.size() == 0) check("R5 extra strobe", 1, 0);
            else check("R2 burst bit", tx_bit, exp_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog", 1, 0);
        finish_run();
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        host_addr = 7'(a); host_wdata = 16'(d); host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        @(negedge clk);
        host_addr = 7'(a); host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = int'(host_rdata);
    endtask

    // Driver: queue the expected burst
    task automatic push_burst();
        for (int k = 0; k < 148; k++) exp_q.push_back(words[k / 16][k % 16]);
        strobes = 0; first_qb = -1; first_fr = -1; gap_bad = 0;
    endtask

    task automatic arm(int fr, int qb, int ctrl);
        wr('h10, qb);
        wr('h11, fr & 'hFFFF);
        wr('h12, fr >> 16);
        wr('h13, ctrl);
    endtask

    task automatic send_pairs(int from, int n);
        for (int k = from; k < from + n; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_i = 8'(k); rx_q = 8'(k ^ 'hF0);
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        int d, tf;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 tx_busy", tx_busy, 0);
        check("R12 rx_win", rx_win, 0);
        check("R12 irq", irq, 0);
        rd('h14, d); check("R12 status", d, 0);
        // R13 read latency with an event register
        wr('h10, 1234); rd('h10, d); check("R13 readback", d, 1234);

        // R1 counters
        while (qb_count != 4999) @(negedge clk);
        tf = int'(frame_count);
        @(negedge clk);
        check("R1 qb wrap", qb_count, 0);
        check("R1 frame step", frame_count, tf + 1);
        @(negedge clk);
        check("R1 qb step", qb_count, 1);

        // R2/R3/R5/R6/R11 transmit
        for (int w = 0; w < 10; w++) begin
            words[w] = 16'('hA5C3 ^ (w * 'h1357));
            wr(w, words[w]);
        end
        wr('h15, 7);
        push_burst();
        tf = int'(frame_count) + 1;
        arm(tf, 100, 0);
        rd('h14, d); check("R9 armed bit", (d >> 3) & 1, 1);
        while (!tx_busy) @(negedge clk);
        wr(9, ~words[9]);            // R11 ignored write
        wr('h13, 1);                 // R11 rejected control
        while (tx_busy) @(negedge clk);
        check("R5 strobe count", strobes, 148);
        check("R5 strobe spacing", gap_bad, 0);
        check("R3 start qb", first_qb, 101);
        check("R3 start frame", first_fr, tf);
        rd('h14, d); check("R6 R11 status", d, 'h05);
        check("R10 irq on", irq, 1);
        wr('h14, 0); rd('h14, d); check("R9 write zero", d, 'h05);
        wr('h14, 1); rd('h14, d); check("R9 clear done", d, 'h04);
        check("R10 irq err", irq, 1);
        wr('h14, 4); @(negedge clk); check("R10 irq off", irq, 0);

        // R4 replace pending event, R10 masked
        wr('h15, 0);
        push_burst();
        tf = int'(frame_count) + 1;
        arm(tf, 200, 0);
        arm(tf, 300, 0);
        while (!tx_busy) @(negedge clk);
        while (tx_busy) @(negedge clk);
        check("R4 replaced start", first_qb, 301);
        check("R11 burst unchanged", exp_q.size(), 0);
        rd('h14, d); check("R6 done again", d & 1, 1);
        check("R10 masked irq", irq, 0);
        wr('h14, 7);

        // R7/R8 receive with two halves
        wr('h15, 2);
        tf = int'(frame_count) + 1;
        arm(tf, 50, 'h05);
        while (!rx_win) @(negedge clk);
        check("R3 rx start qb", qb_count, 51);
        send_pairs(0, 32);
        rd('h14, d); check("R8 first half", d, 'h02);
        check("R10 rx irq", irq, 1);
        check("R7 window open", rx_win, 1);
        wr('h14, 2);
        send_pairs(32, 32);
        check("R7 window closed", rx_win, 0);
        rd('h14, d); check("R8 second half", d, 'h12);
        for (int k = 0; k < 64; k++) begin
            rd('h40 + k, d);
            check("R8 buffer pair", d, ((k & 'hFF) << 8) | ((k ^ 'hF0) & 'hFF));
        end
        wr('h14, 7);

        // R7 zero block count acts as one
        tf = int'(frame_count) + 1;
        arm(tf, 10, 'h01);
        while (!rx_win) @(negedge clk);
        wr('h13, 0);
        rd('h14, d); check("R11 ctrl during rx", (d >> 2) & 1, 1);
        send_pairs(100, 32);
        check("R7 zero count closes", rx_win, 0);
        finish_run();
    end
endmodule